// File: doc/BRIEF.md
# SPI Interrupt Status and Clear Unit

This unit gathers the six interrupt sources of a serial peripheral master and turns them into one level-sensitive interrupt line. Two sources follow FIFO levels against programmable thresholds. One is the transmit side running low and the other is the receive side filling up. The other four are sticky error flags, each set by a one-cycle event pulse: transmit overflow, receive underflow, receive overflow and bus contention.

Software sees a raw status vector and a masked status vector. It acknowledges an error by reading a clear address. Each error has its own clear address, and that read returns the flag's value from before the read. A common clear address drops all four errors at once. The threshold sources are never cleared by reads. They follow the FIFO levels every cycle. The surrounding bus decode supplies register writes and read strobes as single-cycle pulses.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Status bit positions are fixed: bit 0 transmit low, bit 1 transmit overflow, bit 2 receive underflow, bit 3 receive overflow, bit 4 receive full, bit 5 contention. The error vectors `err_evt_i` and `err_clr_rd_i` use index 0 tx overflow, 1 rx underflow, 2 rx overflow, 3 contention.
- R2: Raw bit 0 is 1 exactly when `tx_level_i` is less than or equal to the transmit threshold.
- R3: Raw bit 4 is 1 exactly when `rx_level_i` is strictly greater than the receive threshold.
- R4: Both thresholds reset to 0. A write strobe loads `thr_wdata_i` at the clock edge, and the compare uses the new value from the next cycle on.
- R5: An error event pulse sets its raw bit from the next cycle. The bit then stays set until a clear read reaches it.
- R6: While a per-source clear strobe is high, `clr_rdata_o` shows that source's flag value from before the clear. The flag reads 0 from the next cycle. The other flags keep their values.
- R7: The common clear strobe clears all four error flags at the next edge.
- R8: If an event and a clear for the same flag occur in the same cycle, the flag is 1 in the next cycle.
- R9: The masked status equals raw status AND the 6-bit mask. The mask resets to all ones, and a mask write takes effect in the next cycle.
- R10: `irq_o` is 1 exactly when any masked status bit is 1.
- R11: Clear reads have no effect on raw bits 0 and 4.
- R12: After reset all four error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_level_i | input | LVL_W | Current transmit FIFO level |
| rx_level_i | input | LVL_W | Current receive FIFO level |
| tx_thr_we_i | input | 1 | Transmit threshold write strobe |
| rx_thr_we_i | input | 1 | Receive threshold write strobe |
| thr_wdata_i | input | LVL_W | Threshold write data |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 6 | Mask write data |
| err_evt_i | input | 4 | Error event pulses (index order per R1) |
| err_clr_rd_i | input | 4 | Per-source clear read strobes (index order per R1) |
| all_clr_rd_i | input | 1 | Common clear read strobe |
| raw_o | output | 6 | Raw status |
| masked_o | output | 6 | Masked status |
| clr_rdata_o | output | 1 | Pre-clear value of the flag under a per-source clear read |
| irq_o | output | 1 | Level interrupt |

## Verification
The threshold compares are driven with levels just below, at, and just above each threshold. This separates an at-or-below compare from a strictly-above compare and catches off-by-one errors. Each error index is pulsed on its own, so a crossed wire between event index and status bit shows up as the wrong bit. Per-source clears are issued with the other flags set, which exposes a clear that reaches too far. The common clear is issued with the threshold bits active, to show that it leaves them alone. The test with an event and a clear in the same cycle settles which one has priority. Mask patterns of all zero and a single enabled bit check the masking and the OR that drives `irq_o`.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NSRC = 6;
  localparam int NERR = 4;
  localparam int B_TXE = 0;
  localparam int B_TXO = 1;
  localparam int B_RXU = 2;
  localparam int B_RXO = 3;
  localparam int B_RXF = 4;
  localparam int B_MST = 5;

  function automatic logic [NSRC-1:0] pack_status(input logic txe, input logic rxf,
                                                  input logic [NERR-1:0] err);
    logic [NSRC-1:0] s;
    s        = '0;
    s[B_TXE] = txe;
    s[B_TXO] = err[0];
    s[B_RXU] = err[1];
    s[B_RXO] = err[2];
    s[B_RXF] = rxf;
    s[B_MST] = err[3];
    return s;
  endfunction
endpackage

// File: rtl/spi_irq_thresh.sv
module spi_irq_thresh #(
  parameter int LVL_W = 6,
  parameter bit ABOVE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic             thr_we_i,
  input  logic [LVL_W-1:0] thr_wdata_i,
  output logic             hit_o
);
  logic [LVL_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_q <= '0;
    else if (thr_we_i) thr_q <= thr_wdata_i;
  end

  generate
    if (ABOVE) begin : g_above
      assign hit_o = level_i > thr_q;
    end else begin : g_at_below
      assign hit_o = level_i <= thr_q;
    end
  endgenerate

  AST_THR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_we_i |=> thr_q == $past(thr_wdata_i)); // R4
endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= evt_i[i] | (q & ~clr_i[i]);  // event wins over clear
    end
    assign flag_o[i] = q;

    AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flag_o[i]); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]); // R5
    AST_STICKY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !evt_i[i]) |=> !flag_o[i]); // R6
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             tx_thr_we_i,
  input  logic             rx_thr_we_i,
  input  logic [LVL_W-1:0] thr_wdata_i,
  input  logic             mask_we_i,
  input  logic [5:0]       mask_wdata_i,
  input  logic [3:0]       err_evt_i,
  input  logic [3:0]       err_clr_rd_i,
  input  logic             all_clr_rd_i,
  output logic [5:0]       raw_o,
  output logic [5:0]       masked_o,
  output logic             clr_rdata_o,
  output logic             irq_o
);
  logic            txe_hit, rxf_hit;
  logic [NERR-1:0] err_q, err_clr;
  logic [NSRC-1:0] mask_q;

  spi_irq_thresh #(.LVL_W(LVL_W), .ABOVE(1'b0)) u_tx_thr (
    .clk_i, .rst_ni, .level_i(tx_level_i), .thr_we_i(tx_thr_we_i),
    .thr_wdata_i, .hit_o(txe_hit));

  spi_irq_thresh #(.LVL_W(LVL_W), .ABOVE(1'b1)) u_rx_thr (
    .clk_i, .rst_ni, .level_i(rx_level_i), .thr_we_i(rx_thr_we_i),
    .thr_wdata_i, .hit_o(rxf_hit));

  assign err_clr = err_clr_rd_i | {NERR{all_clr_rd_i}};

  spi_irq_sticky #(.N(NERR)) u_err (
    .clk_i, .rst_ni, .evt_i(err_evt_i), .clr_i(err_clr), .flag_o(err_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  assign raw_o       = pack_status(txe_hit, rxf_hit, err_q);
  assign masked_o    = raw_o & mask_q;
  assign irq_o       = |masked_o;
  assign clr_rdata_o = |(err_q & err_clr_rd_i);  // value before the clear edge

  AST_MASK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && mask_wdata_i == '0) |=> !irq_o); // R10
  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_clr_rd_i && err_evt_i == '0) |=> (raw_o[B_MST] == 1'b0 && raw_o[B_RXO] == 1'b0
      && raw_o[B_RXU] == 1'b0 && raw_o[B_TXO] == 1'b0)); // R7
  AST_MASKED_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o & ~raw_o) == '0); // R9
endmodule

// File: tb/spi_irq_ctrl_test.sv
module spi_irq_ctrl_test;
  localparam int LVL_W = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0, thr_wdata = '0;
  logic tx_thr_we = 0, rx_thr_we = 0, mask_we = 0, all_clr = 0;
  logic [5:0] mask_wdata = '0;
  logic [3:0] evt = '0, clr_rd = '0;
  logic [5:0] raw, masked;
  logic clr_rdata, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_irq_ctrl #(.LVL_W(LVL_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_level_i(tx_level), .rx_level_i(rx_level),
    .tx_thr_we_i(tx_thr_we), .rx_thr_we_i(rx_thr_we), .thr_wdata_i(thr_wdata),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .err_evt_i(evt),
    .err_clr_rd_i(clr_rd), .all_clr_rd_i(all_clr), .raw_o(raw), .masked_o(masked),
    .clr_rdata_o(clr_rdata), .irq_o(irq));

  // status bit for each error index (R1)
  function automatic int sbit(int k);
    case (k)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_all_err();
    evt = 4'hf; cyc(); evt = '0;
  endtask

  task automatic t_reset();
    chk("R12 raw after reset", raw, 6'b000001);
    chk("R9 mask reset ones", masked, 6'b000001);
    chk("R10 irq after reset", irq, 1);
  endtask

  task automatic t_thresh();
    thr_wdata = 6'd5; tx_thr_we = 1; cyc(); tx_thr_we = 0;
    tx_level = 6'd5; #1 chk("R2 tx at threshold", raw[0], 1);
    tx_level = 6'd6; #1 chk("R2 tx above threshold", raw[0], 0);
    tx_level = 6'd4; #1 chk("R2 tx below threshold", raw[0], 1);
    thr_wdata = 6'd3; rx_thr_we = 1; rx_level = 6'd4;
    #1 chk("R4 old rx threshold before edge", raw[4], 1);
    cyc(); rx_thr_we = 0;
    rx_level = 6'd3; #1 chk("R3 rx at threshold", raw[4], 0);
    rx_level = 6'd4; #1 chk("R4 R3 rx above new threshold", raw[4], 1);
    tx_level = 6'd20; rx_level = 6'd0; #1;
  endtask

  task automatic t_sticky();
    for (int k = 0; k < 4; k++) begin
      evt = 4'b1 << k; cyc(); evt = '0;
      chk("R1 R5 event sets bit", raw, 6'b1 << sbit(k));
      cyc(); cyc();
      chk("R5 bit holds", raw, 6'b1 << sbit(k));
      all_clr = 1; cyc(); all_clr = 0;
    end
  endtask

  task automatic t_clear_one();
    for (int k = 0; k < 4; k++) begin
      set_all_err();
      clr_rd = 4'b1 << k; #1 chk("R6 pre-clear readback", clr_rdata, 1);
      cyc(); clr_rd = '0;
      chk("R6 only own bit cleared", raw, 6'b101110 & ~(6'b1 << sbit(k)));
      clr_rd = 4'b1 << k; #1 chk("R6 readback after clear", clr_rdata, 0);
      cyc(); clr_rd = '0;
      all_clr = 1; cyc(); all_clr = 0;
    end
  endtask

  task automatic t_clear_all();
    tx_level = 6'd0; rx_level = 6'd30; set_all_err();
    chk("R5 all set", raw, 6'b111111);
    all_clr = 1; cyc(); all_clr = 0;
    chk("R7 R11 common clear", raw, 6'b010001);
    clr_rd = 4'hf; cyc(); clr_rd = '0;
    chk("R11 threshold bits survive clear reads", raw, 6'b010001);
    tx_level = 6'd20; rx_level = 6'd0; #1;
  endtask

  task automatic t_collide();
    set_all_err();
    evt = 4'b0100; clr_rd = 4'b0100; cyc(); evt = '0; clr_rd = '0;
    chk("R8 event beats own clear", raw[3], 1);
    evt = 4'b1000; all_clr = 1; cyc(); evt = '0; all_clr = 0;
    chk("R8 event beats common clear", raw, 6'b100000);
    all_clr = 1; cyc(); all_clr = 0;
  endtask

  task automatic t_mask();
    set_all_err();
    mask_wdata = 6'b000000; mask_we = 1;
    #1 chk("R9 mask not yet applied", masked, 6'b101110);
    cyc(); mask_we = 0;
    chk("R9 all masked", masked, 0);
    chk("R10 irq off when masked", irq, 0);
    all_clr = 1; cyc(); all_clr = 0;
    mask_wdata = 6'b000010; mask_we = 1; cyc(); mask_we = 0;
    chk("R10 irq off masked source idle", irq, 0);
    evt = 4'b0010; cyc(); evt = '0;
    chk("R9 unmasked-only view", masked, 0);
    evt = 4'b0001; cyc(); evt = '0;
    chk("R9 single enabled bit", masked, 6'b000010);
    chk("R10 irq from single bit", irq, 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_thresh();
    t_sticky();
    t_clear_one();
    t_clear_all();
    t_collide();
    t_mask();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule